// File: doc/BRIEF.md
# Deferred-Normalization Product Chain

This block multiplies a run of floating-point operands into one running product and leaves it unnormalized between steps. Each operand is a sign, a fractional mantissa and a signed exponent. A start strobe loads the first operand. Every later valid operand is multiplied into the held product: the exponents are added and the signs are combined by XOR. The mantissa is held at full width plus three low guard bits, so the bits that slide down after each multiply stay in the register.

Leading-one search and the normalizing left shift run only when the separate normalize command is given. That command produces a storable result one cycle later. The chain length is limited to the number of guard bits. A multiply beyond that limit still runs, but it raises a sticky risk flag, which the next start clears.

Top module: `mdc_chain_mul`

## Requirements
- R1: While reset is held and until the first command after it, res_vld and ovf_risk are 0, and res_sign, res_mant and res_exp are 0.
- R2: A start loads the operand. A normalize given right after it returns the same sign, mantissa and exponent for a normalized operand (mantissa bit 15 set).
- R3: A multiply (mul_vld without start) replaces the held 19-bit mantissa with bits 34..16 of the product of the held mantissa and op_mant. It replaces the exponent with the 8-bit two's-complement sum of both exponents, and the sign with the XOR of both signs.
- R4: Mantissas are fractions with the binary point above the MSB. A multiply of a held mantissa with bit 18 set by an operand with bit 15 set leaves bit 18 or bit 17 set. The truncated low bits stay in the three guard positions.
- R5: Normalize shifts the held mantissa left by its number of leading zeros. It returns the top 16 bits, truncated, as res_mant, and the held exponent minus that count as res_exp.
- R6: A held mantissa of zero normalizes to res_mant 0, res_exp 0 and res_sign 0.
- R7: res_vld is high exactly in the cycle after a normalize command. The result outputs do not change in any cycle without a normalize command.
- R8: ovf_risk is set by a multiply that arrives after three multiplies have been done since the last start. It stays set until the next start clears it. Up to three multiplies leave it at 0.
- R9: When start and mul_vld are high in the same cycle, only the load takes place. The operand is taken as the first operand and the multiply counter restarts.
- R10: When normalize and a multiply fall in the same cycle, the result is the normalized product held before that multiply. The multiply still updates the held product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Load operand as first of a new chain |
| mul_vld | input | 1 | Multiply operand into held product |
| norm | input | 1 | Normalize held product into the result registers |
| op_sign | input | 1 | Operand sign |
| op_mant | input | 16 | Operand mantissa, fraction, normalized when bit 15 is set |
| op_exp | input | 8 | Operand exponent, two's complement |
| res_vld | output | 1 | Result valid, one cycle after normalize |
| res_sign | output | 1 | Result sign |
| res_mant | output | 16 | Normalized result mantissa |
| res_exp | output | 8 | Result exponent |
| ovf_risk | output | 1 | Chain exceeded guard-bit limit |

## Verification
Normalize and multiply can land in the same cycle, and so can start and multiply. The bench raises norm together with mul_vld after a load. It expects that result to equal the loaded operand, and a second normalize to equal the product with the new operand. It also raises start together with mul_vld. It then judges by a following normalize that returns the new operand unchanged, and by three further multiplies that leave the risk flag clear.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_MUL  = 2'd2
  } act_e;
endpackage

// File: rtl/mdc_mul.sv
module mdc_mul #(
  parameter int ACC_W  = 19,
  parameter int MANT_W = 16,
  parameter int EXP_W  = 8
) (
  input  logic [ACC_W-1:0]  acc_m,
  input  logic [EXP_W-1:0]  acc_e,
  input  logic [MANT_W-1:0] op_m,
  input  logic [EXP_W-1:0]  op_e,
  output logic [ACC_W-1:0]  prod_m,
  output logic [EXP_W-1:0]  prod_e
);
  localparam int PROD_W = ACC_W + MANT_W;

  logic [PROD_W-1:0] full;

  always_comb begin
    full   = PROD_W'(acc_m) * PROD_W'(op_m);
    // fraction times fraction: keep the top ACC_W bits, no realignment
    prod_m = full[PROD_W-1 -: ACC_W];
    prod_e = acc_e + op_e;
  end
endmodule

// File: rtl/mdc_lzc.sv
module mdc_lzc #(
  parameter int W     = 19,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     din,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic [W-1:0] hit;

  // one-hot marker of the highest set bit
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_hit
      if (g == W - 1) begin : g_top
        assign hit[g] = din[g];
      end else begin : g_low
        assign hit[g] = din[g] & ~(|din[W-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    cnt  = CNT_W'(W);
    zero = ~(|din);
    for (int i = 0; i < W; i++) begin
      if (hit[i]) cnt = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/mdc_norm.sv
module mdc_norm #(
  parameter int ACC_W  = 19,
  parameter int MANT_W = 16,
  parameter int EXP_W  = 8
) (
  input  logic [ACC_W-1:0]  acc_m,
  input  logic [EXP_W-1:0]  acc_e,
  output logic [MANT_W-1:0] n_m,
  output logic [EXP_W-1:0]  n_e,
  output logic              n_zero
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [CNT_W-1:0] lz;
  logic             is_zero;
  logic [ACC_W-1:0] shifted;

  mdc_lzc #(.W(ACC_W), .CNT_W(CNT_W)) u_lzc (
    .din  (acc_m),
    .cnt  (lz),
    .zero (is_zero)
  );

  always_comb begin
    shifted = acc_m << lz;
    n_zero  = is_zero;
    if (is_zero) begin
      n_m = '0;
      n_e = '0;
    end else begin
      n_m = shifted[ACC_W-1 -: MANT_W];
      n_e = acc_e - EXP_W'(lz);
    end
  end
endmodule

// File: rtl/mdc_chain_mul.sv
module mdc_chain_mul #(
  parameter int MANT_W  = 16,
  parameter int GUARD_W = 3,
  parameter int EXP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mul_vld,
  input  logic              norm,
  input  logic              op_sign,
  input  logic [MANT_W-1:0] op_mant,
  input  logic [EXP_W-1:0]  op_exp,
  output logic              res_vld,
  output logic              res_sign,
  output logic [MANT_W-1:0] res_mant,
  output logic [EXP_W-1:0]  res_exp,
  output logic              ovf_risk
);
  import mdc_pkg::*;

  localparam int ACC_W     = MANT_W + GUARD_W;
  localparam int CHAIN_MAX = GUARD_W;
  localparam int CNT_W     = $clog2(CHAIN_MAX + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // held product state
  logic [ACC_W-1:0]  acc_m_q, acc_m_d;
  logic [EXP_W-1:0]  acc_e_q, acc_e_d;
  logic              acc_s_q, acc_s_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              acc_en;
  act_e              act;

  logic [ACC_W-1:0]  prod_m;
  logic [EXP_W-1:0]  prod_e;
  logic [MANT_W-1:0] n_m;
  logic [EXP_W-1:0]  n_e;
  logic              n_zero;

  logic              rv_q;
  logic              rs_q, rs_d;
  logic [MANT_W-1:0] rm_q, rm_d;
  logic [EXP_W-1:0]  re_q, re_d;

  mdc_mul #(.ACC_W(ACC_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_mul (
    .acc_m  (acc_m_q),
    .acc_e  (acc_e_q),
    .op_m   (op_mant),
    .op_e   (op_exp),
    .prod_m (prod_m),
    .prod_e (prod_e)
  );

  mdc_norm #(.ACC_W(ACC_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .acc_m  (acc_m_q),
    .acc_e  (acc_e_q),
    .n_m    (n_m),
    .n_e    (n_e),
    .n_zero (n_zero)
  );

  // next state: start outranks multiply
  always_comb begin
    if (start)        act = ACT_LOAD;
    else if (mul_vld) act = ACT_MUL;
    else              act = ACT_IDLE;

    acc_m_d = acc_m_q;
    acc_e_d = acc_e_q;
    acc_s_d = acc_s_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    acc_en  = 1'b0;

    case (act)
      ACT_LOAD: begin
        acc_en  = 1'b1;
        acc_m_d = {op_mant, {GUARD_W{1'b0}}};
        acc_e_d = op_exp;
        acc_s_d = op_sign;
        cnt_d   = '0;
        ovf_d   = 1'b0;
      end
      ACT_MUL: begin
        acc_en  = 1'b1;
        acc_m_d = prod_m;
        acc_e_d = prod_e;
        acc_s_d = acc_s_q ^ op_sign;
        if (cnt_q == CNT_W'(CHAIN_MAX)) ovf_d = 1'b1;
        else                            cnt_d = cnt_q + 1'b1;
      end
      default: ;
    endcase

    rs_d = acc_s_q & ~n_zero;
    rm_d = n_m;
    re_d = n_e;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_m_q <= '0;
      acc_e_q <= '0;
      acc_s_q <= 1'b0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (acc_en) begin
      acc_m_q <= acc_m_d;
      acc_e_q <= acc_e_d;
      acc_s_q <= acc_s_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rv_q <= 1'b0;
      rs_q <= 1'b0;
      rm_q <= '0;
      re_q <= '0;
    end else begin
      rv_q <= norm;
      if (norm) begin
        rs_q <= rs_d;
        rm_q <= rm_d;
        re_q <= re_d;
      end
    end
  end

  assign res_vld  = rv_q;
  assign res_sign = rs_q;
  assign res_mant = rm_q;
  assign res_exp  = re_q;
  assign ovf_risk = ovf_q;

  AST_LEAD_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (act == ACT_MUL && acc_m_q[ACC_W-1] && op_mant[MANT_W-1])
      |=> (acc_m_q[ACC_W-1] | acc_m_q[ACC_W-2])); // R4
  AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_vld && res_mant != '0) |-> res_mant[MANT_W-1]); // R5
  AST_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_vld && res_mant == '0) |-> (res_exp == '0 && !res_sign)); // R6
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    norm |=> res_vld); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !norm |=> ($stable(res_mant) && $stable(res_exp) && !res_vld)); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> !ovf_risk); // R8
endmodule

// File: tb/mdc_chain_mul_tb.sv
module mdc_chain_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, mul_vld, norm, op_sign;
  logic [15:0] op_mant;
  logic [7:0]  op_exp;
  logic        res_vld, res_sign, ovf_risk;
  logic [15:0] res_mant;
  logic [7:0]  res_exp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the held product
  longint     bm;
  logic [7:0] be;
  bit         bs;

  always #4 clk = ~clk;

  mdc_chain_mul dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mul_vld(mul_vld), .norm(norm),
    .op_sign(op_sign), .op_mant(op_mant), .op_exp(op_exp),
    .res_vld(res_vld), .res_sign(res_sign), .res_mant(res_mant),
    .res_exp(res_exp), .ovf_risk(ovf_risk)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    start = 0; mul_vld = 0; norm = 0; op_sign = 0; op_mant = '0; op_exp = '0;
  endtask

  task automatic ref_norm(output logic [15:0] rm, output logic [7:0] re,
                          output bit rs);
    longint m = bm;
    int sh = 0;
    if (m == 0) begin
      rm = '0; re = '0; rs = 0;
    end else begin
      while (((m >> 18) & 1) == 0) begin
        m = m << 1; sh++;
      end
      rm = 16'((m >> 3) & 16'hFFFF);
      re = be - 8'(sh);
      rs = bs;
    end
  endtask

  task automatic do_load(input bit s, input logic [15:0] m, input logic [7:0] e);
    @(negedge clk);
    clear_in(); start = 1; op_sign = s; op_mant = m; op_exp = e;
    @(negedge clk);
    clear_in();
    bm = longint'(m) << 3; be = e; bs = s;
  endtask

  task automatic do_mul(input bit s, input logic [15:0] m, input logic [7:0] e);
    @(negedge clk);
    clear_in(); mul_vld = 1; op_sign = s; op_mant = m; op_exp = e;
    @(negedge clk);
    clear_in();
    bm = (bm * longint'(m)) >> 16; be = be + e; bs = bs ^ s;
  endtask

  task automatic norm_check(input string req);
    logic [15:0] rm; logic [7:0] re; bit rs;
    ref_norm(rm, re, rs);
    @(negedge clk);
    clear_in(); norm = 1;
    @(negedge clk);
    clear_in();
    check({req, " vld"},  res_vld,  1);
    check({req, " mant"}, res_mant, rm);
    check({req, " exp"},  res_exp,  re);
    check({req, " sign"}, res_sign, rs);
  endtask

  task automatic t_reset();
    check("R1 vld",  res_vld,  0);
    check("R1 ovf",  ovf_risk, 0);
    check("R1 mant", res_mant, 0);
    check("R1 exp",  res_exp,  0);
    check("R1 sign", res_sign, 0);
  endtask

  task automatic t_load();
    do_load(1, 16'hC35A, 8'h05);
    norm_check("R2 passthrough");
    check("R2 mant direct", res_mant, 16'hC35A);
    @(negedge clk);
    check("R7 vld drops", res_vld, 0);
    check("R7 hold mant", res_mant, 16'hC35A);
  endtask

  task automatic t_chain();
    do_load(0, 16'h8000, 8'h01);
    do_mul(0, 16'h8000, 8'h02);
    norm_check("R3 half times half");
    check("R5 shift one exp", res_exp, 8'h02);
    do_load(1, 16'hFFFF, 8'hFE);
    do_mul(1, 16'hABCD, 8'h03);
    do_mul(0, 16'h9001, 8'hFF);
    do_mul(1, 16'hF0F3, 8'h04);
    norm_check("R4 three-step chain");
    check("R8 three muls no flag", ovf_risk, 0);
  endtask

  task automatic t_ovf();
    do_load(0, 16'hA000, 8'h00);
    do_mul(0, 16'hA000, 8'h00);
    do_mul(0, 16'hA000, 8'h00);
    do_mul(0, 16'hA000, 8'h00);
    check("R8 at limit", ovf_risk, 0);
    do_mul(0, 16'hA000, 8'h00);
    check("R8 past limit", ovf_risk, 1);
    norm_check("R5 deep chain");
    check("R8 sticky", ovf_risk, 1);
    do_load(0, 16'h8000, 8'h00);
    check("R8 start clears", ovf_risk, 0);
  endtask

  task automatic t_zero();
    do_load(1, 16'h0000, 8'h33);
    do_mul(1, 16'h8001, 8'h11);
    norm_check("R6 zero");
    check("R6 zero exp", res_exp, 0);
    check("R6 zero sign", res_sign, 0);
  endtask

  task automatic t_start_mul();
    do_load(0, 16'h8000, 8'h00);
    @(negedge clk);
    clear_in(); start = 1; mul_vld = 1; op_sign = 1; op_mant = 16'hB111; op_exp = 8'h07;
    @(negedge clk);
    clear_in();
    bm = longint'(16'hB111) << 3; be = 8'h07; bs = 1;
    norm_check("R9 start wins");
    do_mul(0, 16'h8000, 8'h00);
    do_mul(0, 16'h8000, 8'h00);
    do_mul(0, 16'h8000, 8'h00);
    check("R9 counter restarted", ovf_risk, 0);
  endtask

  task automatic t_norm_mul();
    logic [15:0] rm; logic [7:0] re; bit rs;
    do_load(0, 16'hE000, 8'h10);
    ref_norm(rm, re, rs);
    @(negedge clk);
    clear_in(); norm = 1; mul_vld = 1; op_mant = 16'hC000; op_exp = 8'h01;
    @(negedge clk);
    clear_in();
    check("R10 pre-multiply mant", res_mant, rm);
    check("R10 pre-multiply exp", res_exp, re);
    bm = (bm * longint'(16'hC000)) >> 16; be = be + 8'h01;
    norm_check("R10 multiply applied");
  endtask

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_chain();
    t_ovf();
    t_zero();
    t_start_mul();
    t_norm_mul();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule